// File: doc/BRIEF.md
# Link Bring-Up Monitor with Speed-Change Recovery

This block watches a serial link after its training state machine has been switched on. At a fixed poll interval it samples two debug status words from the link controller. From them it decides whether the link is up, still training, or stuck partway through a speed change. A link counts as stuck when the receiver-lock recovery state is showing and the PHY reports no valid receive data.

When the link is not up, the block reads the PHY receive-status register through a register access port. If the link is stuck, it pulses two receiver override bits in the PHY. The pulse is a read-modify-write that sets the bits, a hold window, and a second read-modify-write that clears them. Every poll that does not find the link up counts towards a limit, and reaching the limit declares failure. At that moment the block captures both debug words for later inspection.

The PHY access port is valid/ready. Once the block raises `phy_req_valid`, the request and its payload stay fixed until the PHY takes it with `phy_req_ready`. The block keeps at most one transaction in flight. It raises `phy_rsp_ready` only while it is waiting for the answer to a request the PHY has already accepted, and every request, read or write, gets exactly one response beat. Enable, the debug words and the result flags are plain level signals.

Top module: `link_watch`

## Requirements
- R1: After reset, `link_up`, `link_fail`, both snapshot words and `phy_req_valid` are 0. While `en` is low and no transaction is in flight, no PHY request is issued.
- R2: At a poll, the link is taken as up when bit 4 of `dbg_link_word` is 1 and bit 29 is 0. `link_up` then rises and no PHY request is issued for that poll.
- R3: At a poll where bit 4 of `dbg_link_word` is set but bit 29 is also set, the link is not up. Polling continues and `link_up` stays low.
- R4: Each poll that finds the link not up issues one read of PHY address 0x100D. If bit 0 of the returned value is 1, no PHY write follows, whatever the training state.
- R5: When bit 0 of that read is 0 and bits 5:0 of `dbg_state_word` equal 0x0D at the poll, the block reads PHY address 0x1005 and writes back the value with bits 5 and 3 set (mask 0x0028), leaving the other bits unchanged. After the hold window it reads 0x1005 again and writes back the value with those two bits cleared.
- R6: When bit 0 of the 0x100D read is 0 but bits 5:0 of `dbg_state_word` differ from 0x0D, no PHY write is issued.
- R7: At least `HOLD_US` × `CYC_PER_US` clock cycles separate the acceptance of the setting write from the acceptance of the clearing read.
- R8: Polls are at least `POLL_US` × `CYC_PER_US` cycles apart. After `MAX_POLLS` polls that do not find the link up, `link_fail` rises and the snapshot outputs hold both debug words as they were at that moment.
- R9: `link_up` and `link_fail` stay set while `en` stays high. Debug word changes do not alter them. Dropping `en` clears both flags in the next cycle, and a later rise of `en` restarts the poll count from zero.
- R10: While `phy_req_valid` is high and `phy_req_ready` is low, valid, address, write flag and write data hold steady. `phy_rsp_ready` rises only after a request has been accepted.
- R11: `link_up` and `link_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Training enabled; low returns the monitor to idle |
| dbg_state_word | input | 32 | First debug word; bits 5:0 are the training state |
| dbg_link_word | input | 32 | Second debug word; bit 4 link up, bit 29 in training |
| phy_req_valid | output | 1 | PHY request valid |
| phy_req_ready | input | 1 | PHY accepts the request |
| phy_req_write | output | 1 | 1 = write, 0 = read |
| phy_req_addr | output | 16 | PHY register address |
| phy_req_wdata | output | 16 | PHY write data |
| phy_rsp_valid | input | 1 | PHY response valid |
| phy_rsp_ready | output | 1 | Block is waiting for a response |
| phy_rsp_rdata | input | 16 | PHY read data |
| link_up | output | 1 | Sticky link-up flag |
| link_fail | output | 1 | Sticky bring-up failure flag |
| snap_state_word | output | 32 | First debug word captured at failure |
| snap_link_word | output | 32 | Second debug word captured at failure |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- request stability under back-pressure and response readiness only after an accepted request;
- the two flags being mutually exclusive, sticky while enabled and cleared after enable drops;
- no PHY traffic once the link is up.

Only the directed scenarios can show the decisions that depend on data and sequences. These are:
- which debug-word patterns count as up, and when a read of 0x100D leads to recovery;
- the exact values written to the override register and the length of the hold window;
- the number of polls before failure and the contents of the snapshot.

// File: rtl/link_watch_pkg.sv
package link_watch_pkg;

  typedef enum logic [1:0] {
    PHY_OP_READ = 2'd0,
    PHY_OP_SET  = 2'd1,
    PHY_OP_CLR  = 2'd2
  } phy_op_e;

  typedef enum logic [3:0] {
    M_IDLE  = 4'd0,
    M_WAIT  = 4'd1,
    M_RDRX  = 4'd2,
    M_SET   = 4'd3,
    M_HOLD  = 4'd4,
    M_CLR   = 4'd5,
    M_NEXT  = 4'd6,
    M_UP    = 4'd7,
    M_FAIL  = 4'd8,
    M_DRAIN = 4'd9
  } mon_state_e;

  localparam int PHY_AW = 16;
  localparam int PHY_DW = 16;

  // PHY register map used by the monitor
  localparam logic [PHY_AW-1:0] RX_STAT_ADDR = 16'h100D;
  localparam logic [PHY_AW-1:0] RX_OVRD_ADDR = 16'h1005;
  localparam logic [PHY_DW-1:0] RX_OVRD_BITS = 16'h0028;
  localparam int                RX_VALID_BIT = 0;

  // debug word fields
  localparam int       LINK_UP_BIT    = 4;
  localparam int       TRAINING_BIT   = 29;
  localparam int       STATE_W        = 6;
  localparam logic [STATE_W-1:0] STATE_RCV_LOCK = 6'h0D;

endpackage

// File: rtl/lw_interval_timer.sv
module lw_interval_timer #(
  parameter int CYC_PER_US = 125,
  parameter int UW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [UW-1:0] len_us,
  output logic          done
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] pre;
  logic [UW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        pre <= '0;
        cnt <= (len_us == '0) ? UW'(1) : len_us;
        run <= 1'b1;
      end else if (run) begin
        if (pre == PRE_LAST) begin
          pre <= '0;
          if (cnt == UW'(1)) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt - UW'(1);
          end
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lw_phy_rmw.sv
module lw_phy_rmw
  import link_watch_pkg::*;
#(
  parameter int AW = PHY_AW,
  parameter int DW = PHY_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  phy_op_e       op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] mask,
  input  logic          abort,
  output logic          done,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_rdata
);
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RREQ = 3'd1,
    S_RRSP = 3'd2,
    S_WREQ = 3'd3,
    S_WRSP = 3'd4
  } seq_state_e;

  seq_state_e    st;
  phy_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= PHY_OP_READ;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          addr_q <= addr;
          mask_q <= mask;
          st     <= S_RREQ;
        end
        S_RREQ: if (req_ready) st <= S_RRSP;
        S_RRSP: if (rsp_valid) begin
          rdata <= rsp_rdata;
          if (op_q == PHY_OP_READ || abort) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            wdata_q <= (op_q == PHY_OP_SET) ? (rsp_rdata | mask_q)
                                            : (rsp_rdata & ~mask_q);
            st      <= S_WREQ;
          end
        end
        S_WREQ: if (req_ready) st <= S_WRSP;
        S_WRSP: if (rsp_valid) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign req_valid = (st == S_RREQ) || (st == S_WREQ);
  assign req_write = (st == S_WREQ);
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign rsp_ready = (st == S_RRSP) || (st == S_WRSP);

  // R10: request held steady under back-pressure
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_write) && $stable(req_wdata)));

  // R10: response readiness only follows an accepted request
  p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(req_valid && req_ready));

endmodule

// File: rtl/link_watch.sv
module link_watch
  import link_watch_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int POLL_US    = 10,
  parameter int HOLD_US    = 3000,
  parameter int MAX_POLLS  = 4000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [31:0]          dbg_state_word,
  input  logic [31:0]          dbg_link_word,
  output logic                 phy_req_valid,
  input  logic                 phy_req_ready,
  output logic                 phy_req_write,
  output logic [PHY_AW-1:0]    phy_req_addr,
  output logic [PHY_DW-1:0]    phy_req_wdata,
  input  logic                 phy_rsp_valid,
  output logic                 phy_rsp_ready,
  input  logic [PHY_DW-1:0]    phy_rsp_rdata,
  output logic                 link_up,
  output logic                 link_fail,
  output logic [31:0]          snap_state_word,
  output logic [31:0]          snap_link_word
);
  localparam int MAX_US = (POLL_US > HOLD_US) ? POLL_US : HOLD_US;
  localparam int UW     = $clog2(MAX_US + 1);
  localparam int CW     = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(MAX_POLLS - 1);

  mon_state_e          st, st_d;
  logic [CW-1:0]       polls;
  logic [STATE_W-1:0]  state_q;
  logic                up_q, fail_q;

  logic                tmr_start, tmr_done;
  logic [UW-1:0]       tmr_len;
  logic                seq_start, seq_done, seq_busy, seq_abort;
  phy_op_e             seq_op;
  logic [PHY_AW-1:0]   seq_addr;
  logic [PHY_DW-1:0]   seq_mask, seq_rdata;
  logic                up_set, fail_set, poll_inc, poll_clr, state_ld;
  logic                link_ok;

  assign link_ok = dbg_link_word[LINK_UP_BIT] && !dbg_link_word[TRAINING_BIT];

  lw_interval_timer #(.CYC_PER_US(CYC_PER_US), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .len_us(tmr_len), .done(tmr_done)
  );

  lw_phy_rmw #(.AW(PHY_AW), .DW(PHY_DW)) u_rmw (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .op(seq_op), .addr(seq_addr),
    .mask(seq_mask), .abort(seq_abort), .done(seq_done), .busy(seq_busy),
    .rdata(seq_rdata), .req_valid(phy_req_valid), .req_ready(phy_req_ready),
    .req_write(phy_req_write), .req_addr(phy_req_addr), .req_wdata(phy_req_wdata),
    .rsp_valid(phy_rsp_valid), .rsp_ready(phy_rsp_ready), .rsp_rdata(phy_rsp_rdata)
  );

  assign seq_abort = !en || (st == M_DRAIN);

  always_comb begin
    st_d      = st;
    tmr_start = 1'b0;
    tmr_len   = UW'(POLL_US);
    seq_start = 1'b0;
    seq_op    = PHY_OP_READ;
    seq_addr  = RX_STAT_ADDR;
    seq_mask  = RX_OVRD_BITS;
    up_set    = 1'b0;
    fail_set  = 1'b0;
    poll_inc  = 1'b0;
    poll_clr  = 1'b0;
    state_ld  = 1'b0;
    if (!en) begin
      st_d = seq_busy ? M_DRAIN : M_IDLE;
    end else begin
      case (st)
        M_IDLE: begin
          tmr_start = 1'b1;
          poll_clr  = 1'b1;
          st_d      = M_WAIT;
        end
        M_WAIT: if (tmr_done) begin
          if (link_ok) begin
            up_set = 1'b1;
            st_d   = M_UP;
          end else begin
            state_ld  = 1'b1;
            seq_start = 1'b1;
            st_d      = M_RDRX;
          end
        end
        M_RDRX: if (seq_done) begin
          if (!seq_rdata[RX_VALID_BIT] && state_q == STATE_RCV_LOCK) begin
            seq_start = 1'b1;
            seq_op    = PHY_OP_SET;
            seq_addr  = RX_OVRD_ADDR;
            st_d      = M_SET;
          end else begin
            st_d = M_NEXT;
          end
        end
        M_SET: if (seq_done) begin
          tmr_start = 1'b1;
          tmr_len   = UW'(HOLD_US);
          st_d      = M_HOLD;
        end
        M_HOLD: if (tmr_done) begin
          seq_start = 1'b1;
          seq_op    = PHY_OP_CLR;
          seq_addr  = RX_OVRD_ADDR;
          st_d      = M_CLR;
        end
        M_CLR: if (seq_done) st_d = M_NEXT;
        M_NEXT: begin
          if (polls == LAST_POLL) begin
            fail_set = 1'b1;
            st_d     = M_FAIL;
          end else begin
            poll_inc  = 1'b1;
            tmr_start = 1'b1;
            st_d      = M_WAIT;
          end
        end
        M_UP, M_FAIL: st_d = st;
        M_DRAIN: if (!seq_busy) st_d = M_IDLE;
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= M_IDLE;
      polls           <= '0;
      state_q         <= '0;
      up_q            <= 1'b0;
      fail_q          <= 1'b0;
      snap_state_word <= '0;
      snap_link_word  <= '0;
    end else begin
      st <= st_d;
      if (poll_clr)      polls <= '0;
      else if (poll_inc) polls <= polls + CW'(1);
      if (state_ld) state_q <= dbg_state_word[STATE_W-1:0];
      up_q   <= en && (up_q || up_set);
      fail_q <= en && (fail_q || fail_set);
      if (fail_set) begin
        snap_state_word <= dbg_state_word;
        snap_link_word  <= dbg_link_word;
      end
    end
  end

  assign link_up   = up_q;
  assign link_fail = fail_q;

  // R11: flags are exclusive
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && link_fail));

  // R9: sticky while enabled
  p_up_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && link_up) |=> link_up);
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && link_fail) |=> link_fail);

  // R9: dropping enable clears both flags
  p_clear_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!link_up && !link_fail));

  // R2: no PHY traffic once the link is declared up
  p_quiet_when_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> !phy_req_valid);

endmodule

// File: tb/tb_link_watch.sv
`timescale 1ns/1ps
module tb_link_watch;
  localparam int CYC  = 4;
  localparam int POLL = 10;
  localparam int HOLD = 50;
  localparam int MAXP = 6;
  localparam int POLL_CYC = CYC * POLL;
  localparam int HOLD_CYC = CYC * HOLD;

  logic        clk = 1'b0;
  logic        rst_n, en;
  logic [31:0] dbg0, dbg1;
  logic        phy_req_valid, phy_req_ready, phy_req_write;
  logic [15:0] phy_req_addr, phy_req_wdata;
  logic        phy_rsp_valid, phy_rsp_ready;
  logic [15:0] phy_rsp_rdata;
  logic        link_up, link_fail;
  logic [31:0] snap0, snap1;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  link_watch #(.CYC_PER_US(CYC), .POLL_US(POLL), .HOLD_US(HOLD), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dbg_state_word(dbg0), .dbg_link_word(dbg1),
    .phy_req_valid(phy_req_valid), .phy_req_ready(phy_req_ready),
    .phy_req_write(phy_req_write), .phy_req_addr(phy_req_addr),
    .phy_req_wdata(phy_req_wdata), .phy_rsp_valid(phy_rsp_valid),
    .phy_rsp_ready(phy_rsp_ready), .phy_rsp_rdata(phy_rsp_rdata),
    .link_up(link_up), .link_fail(link_fail),
    .snap_state_word(snap0), .snap_link_word(snap1)
  );

  // PHY model
  int          cyc = 0, stall_mode = 0;
  int          req_seen = 0, rx_rd_n = 0, ovrd_wr_n = 0, viol = 0;
  int          set_wr_cyc = 0, clr_rd_cyc = 0;
  logic [15:0] ovrd_reg = 16'h8001, rxstat_reg = 16'h0000;
  logic [15:0] wr_val [0:3];
  logic        prev_v = 0, prev_rdy = 0, prev_wr = 0;
  logic [15:0] prev_addr = 0, prev_wdata = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      phy_rsp_valid <= 1'b0;
      phy_rsp_rdata <= 16'h0;
      phy_req_ready <= 1'b1;
      prev_v = 0;
    end else begin
      if (prev_v && !prev_rdy && (!phy_req_valid || phy_req_addr != prev_addr ||
          phy_req_write != prev_wr || phy_req_wdata != prev_wdata)) viol++;
      prev_v = phy_req_valid; prev_rdy = phy_req_ready; prev_wr = phy_req_write;
      prev_addr = phy_req_addr; prev_wdata = phy_req_wdata;
      phy_req_ready <= (stall_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (phy_rsp_valid && phy_rsp_ready) phy_rsp_valid <= 1'b0;
      if (phy_req_valid && phy_req_ready) begin
        req_seen++;
        phy_rsp_valid <= 1'b1;
        if (phy_req_write) begin
          phy_rsp_rdata <= 16'h0;
          if (phy_req_addr == 16'h1005) begin
            if (ovrd_wr_n < 4) wr_val[ovrd_wr_n] = phy_req_wdata;
            if (ovrd_wr_n == 0) set_wr_cyc = cyc;
            ovrd_wr_n++;
            ovrd_reg = phy_req_wdata;
          end
        end else if (phy_req_addr == 16'h100D) begin
          rx_rd_n++;
          phy_rsp_rdata <= rxstat_reg;
        end else if (phy_req_addr == 16'h1005) begin
          if (ovrd_wr_n == 1) clr_rd_cyc = cyc;
          phy_rsp_rdata <= ovrd_reg;
        end else begin
          phy_rsp_rdata <= 16'hDEAD;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_and_clear();
    @(negedge clk);
    en = 1'b0;
    repeat (6) @(negedge clk);
    req_seen = 0; rx_rd_n = 0; ovrd_wr_n = 0;
  endtask

  task automatic wait_up(input int lim, output int n);
    n = 0;
    while (n < lim && !link_up) begin @(negedge clk); n++; end
  endtask

  task automatic wait_fail(input int lim, output int n);
    n = 0;
    while (n < lim && !link_fail) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk(link_up == 0, "R1", "link_up after reset", link_up, 0);
    chk(link_fail == 0, "R1", "link_fail after reset", link_fail, 0);
    chk(snap0 == 0 && snap1 == 0, "R1", "snapshot after reset", snap0 | snap1, 0);
    chk(phy_req_valid == 0, "R1", "req_valid after reset", phy_req_valid, 0);
    repeat (100) @(negedge clk);
    chk(req_seen == 0, "R1", "requests while disabled", req_seen, 0);
  endtask

  task automatic t_link_up();
    int n;
    dbg0 = 32'h0; dbg1 = 32'h0000_0010;
    en = 1'b1;
    wait_up(200, n);
    chk(link_up == 1, "R2", "link_up on clean link word", link_up, 1);
    chk(n >= POLL_CYC - 2 && n <= POLL_CYC + 6, "R2", "cycles to first poll", n, POLL_CYC);
    chk(req_seen == 0, "R2", "PHY requests when up", req_seen, 0);
    idle_and_clear();
  endtask

  task automatic t_training();
    int n;
    dbg0 = 32'h0000_000D; dbg1 = 32'h2000_0010; rxstat_reg = 16'h0001;
    en = 1'b1;
    repeat (4 * (POLL_CYC + 10)) @(negedge clk);
    chk(link_up == 0, "R3", "link_up with training bit set", link_up, 0);
    chk(rx_rd_n >= 3, "R4", "receive-status reads", rx_rd_n, 3);
    chk(ovrd_wr_n == 0, "R4", "writes with rx valid set", ovrd_wr_n, 0);
    dbg1 = 32'h0000_0010;
    wait_up(200, n);
    chk(link_up == 1, "R3", "link_up after training bit clears", link_up, 1);
    idle_and_clear();
  endtask

  task automatic t_recovery();
    int n, gap;
    stall_mode = 1;
    ovrd_reg = 16'h8001; rxstat_reg = 16'h0000;
    dbg0 = 32'hFFFF_FFCD; dbg1 = 32'h0;
    en = 1'b1;
    n = 0;
    while (n < 2000 && ovrd_wr_n < 2) begin @(negedge clk); n++; end
    rxstat_reg = 16'h0001;
    chk(ovrd_wr_n == 2, "R5", "override write count", ovrd_wr_n, 2);
    chk(wr_val[0] == 16'h8029, "R5", "setting write value", wr_val[0], 16'h8029);
    chk(wr_val[1] == 16'h8001, "R5", "clearing write value", wr_val[1], 16'h8001);
    gap = clr_rd_cyc - set_wr_cyc;
    chk(gap >= HOLD_CYC, "R7", "hold window minimum", gap, HOLD_CYC);
    chk(gap <= HOLD_CYC + 20, "R7", "hold window maximum", gap, HOLD_CYC + 20);
    chk(viol == 0, "R10", "request changed under back-pressure", viol, 0);
    dbg1 = 32'h0000_0010;
    wait_up(300, n);
    chk(link_up == 1, "R5", "link_up after recovery", link_up, 1);
    idle_and_clear();
    stall_mode = 0;
  endtask

  task automatic t_not_stuck();
    dbg0 = 32'h0000_002D; dbg1 = 32'h0; rxstat_reg = 16'h0000;
    en = 1'b1;
    repeat (4 * (POLL_CYC + 10)) @(negedge clk);
    chk(ovrd_wr_n == 0, "R6", "writes in other state", ovrd_wr_n, 0);
    chk(rx_rd_n >= 3, "R6", "receive-status reads", rx_rd_n, 3);
    idle_and_clear();
  endtask

  task automatic t_fail_sticky();
    int n;
    dbg0 = 32'h1234_5611; dbg1 = 32'h2000_0000; rxstat_reg = 16'h0001;
    en = 1'b1;
    wait_fail(2000, n);
    chk(link_fail == 1, "R8", "link_fail after poll limit", link_fail, 1);
    chk(rx_rd_n == MAXP, "R8", "polls before failure", rx_rd_n, MAXP);
    chk(n >= MAXP * POLL_CYC, "R8", "poll spacing", n, MAXP * POLL_CYC);
    chk(snap0 == 32'h1234_5611, "R8", "state word snapshot", snap0, 32'h1234_5611);
    chk(snap1 == 32'h2000_0000, "R8", "link word snapshot", snap1, 32'h2000_0000);
    chk(link_up == 0, "R11", "link_up with link_fail", link_up, 0);
    dbg1 = 32'h0000_0010;
    repeat (3 * POLL_CYC) @(negedge clk);
    chk(link_fail == 1 && link_up == 0, "R9", "flags sticky", {link_up, link_fail}, 2'b01);
    en = 1'b0;
    @(negedge clk);
    chk(link_fail == 0 && link_up == 0, "R9", "flags cleared on disable",
        {link_up, link_fail}, 2'b00);
    dbg1 = 32'h2000_0000;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (3 * POLL_CYC) @(negedge clk);
    chk(link_fail == 0, "R9", "count restarts on re-enable", link_fail, 0);
    idle_and_clear();
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; dbg0 = 32'h0; dbg1 = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_link_up();
    t_training();
    t_recovery();
    t_not_stuck();
    t_fail_sticky();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule